// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the configuration of a clock synthesizer: a 9-bit feedback divide value, a 2-bit post-divide code, a 3-bit test-select code and a 4-bit spread code. Two paths can load these fields. A three-wire serial port (clock, data, load strobe) fills an 18-bit shift register. A parallel port carries the feedback and post-divide values on pins and has a level-sensitive load control. The block does not contain the PLL, the dividers or the modulator. It only delivers the held values to them, together with a one-cycle strobe whenever any of the values changes.

Every input is sampled in one fast system clock domain. The serial clock, the serial strobe and the parallel control each pass through a two-stage synchronizer, and their edges are found in that domain. The data pins pass through synchronizers of the same depth, so they stay aligned with the control signals. The parallel path always has priority. While its control is low, the divide fields follow the pins and the test and spread fields are held at their quiet value of zero.

Top module: `div_cfg_port`

## Requirements
- R1: Each rising edge of the serial clock shifts the shift register by one place. The serial data bit enters bit 0, and the register is 18 bits long.
- R2: After 18 shifts, the first bit sent sits in bit 17. The fields are read as spread code = bits 17:14, test select = bits 13:11, post-divide = bits 10:9, feedback divide = bits 8:0. Each field is sent most significant bit first.
- R3: While the serial strobe is high and the parallel control is high, the outputs follow the shift register. After the strobe falls, the outputs hold, and further shifting does not change them.
- R4: While the parallel control is low, the feedback and post-divide outputs follow the parallel pins. After the control rises, pin changes have no effect.
- R5: While the parallel control is low, a serial strobe has no effect on any output.
- R6: While the parallel control is low, the test-select output is 000 and the spread output is 0000, whatever was loaded serially before.
- R7: After reset, all four fields are zero and the update strobe is low.
- R8: The update strobe is high for exactly those cycles in which the outputs differ from their values one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial port clock (asynchronous) |
| serData | input | 1 | Serial port data |
| serLoad | input | 1 | Serial load strobe: transparent while high |
| parLoad | input | 1 | Parallel load control: transparent while low |
| parM | input | 9 | Parallel feedback divide value |
| parN | input | 2 | Parallel post-divide code |
| outM | output | 9 | Held feedback divide value |
| outN | output | 2 | Held post-divide code |
| outT | output | 3 | Held test-select code |
| outSs | output | 4 | Held spread code |
| updatePulse | output | 1 | High for one cycle after any field changes |

## Verification
Two functions can fall in the same system cycle: a serial shift and a transparent serial latch. The bench raises the serial strobe and keeps it high while another serial clock edge arrives. The scoreboard then expects two separate updates: first the contents from before the shift, then the shifted word. A second pairing lets a serial strobe occur while the parallel control is low. In that case the priority rule says the outputs must not move, so any unexpected update strobe is counted as a failure.

// File: rtl/div_cfg_pkg.sv
package div_cfg_pkg;
  localparam int M_W  = 9;
  localparam int N_W  = 2;
  localparam int T_W  = 3;
  localparam int SS_W = 4;
  localparam int SH_W = M_W + N_W + T_W + SS_W;

  typedef struct packed {
    logic [SS_W-1:0] ss;
    logic [T_W-1:0]  t;
    logic [N_W-1:0]  n;
    logic [M_W-1:0]  m;
  } cfg_t;

  typedef struct packed {
    logic shiftEn;
    logic serLatch;
    logic parFollow;
  } strb_t;
endpackage

// File: rtl/div_cfg_sync.sv
module div_cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/div_cfg_ctrl.sv
module div_cfg_ctrl
  import div_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  serClk,
  input  logic  serLoad,
  input  logic  parLoad,
  output strb_t strb
);
  logic [2:0] ctlS;
  logic       serClkD;

  // parLoad synchronizes to its inactive (high) level during reset
  div_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) ctlSync_i (
    .clk(clk), .rstN(rstN), .d({parLoad, serLoad, serClk}), .q(ctlS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkD <= 1'b0;
    else       serClkD <= ctlS[0];
  end

  always_comb begin
    strb.shiftEn   = ctlS[0] & ~serClkD;
    strb.parFollow = ~ctlS[2];
    strb.serLatch  = ctlS[1] & ctlS[2];
  end

  // R1
  shift_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn);
endmodule

// File: rtl/div_cfg_dp.sv
module div_cfg_dp
  import div_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  strb_t          strb,
  input  logic           serData,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output cfg_t           cfgQ,
  output logic           updatePulse
);
  localparam int DW = 1 + M_W + N_W;

  logic [DW-1:0]   datS;
  logic            serDataS;
  logic [M_W-1:0]  parMS;
  logic [N_W-1:0]  parNS;
  logic [SH_W-1:0] shReg;
  cfg_t            cfgNext;

  div_cfg_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST('0)) datSync_i (
    .clk(clk), .rstN(rstN), .d({serData, parM, parN}), .q(datS)
  );
  assign {serDataS, parMS, parNS} = datS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (strb.shiftEn) shReg <= {shReg[SH_W-2:0], serDataS};
  end

  always_comb begin
    cfgNext = cfgQ;
    if (strb.parFollow) begin
      cfgNext.m  = parMS;
      cfgNext.n  = parNS;
      cfgNext.t  = '0;
      cfgNext.ss = '0;
    end else if (strb.serLatch) begin
      cfgNext = cfg_t'(shReg);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ        <= '0;
      updatePulse <= 1'b0;
    end else begin
      cfgQ        <= cfgNext;
      updatePulse <= (cfgNext != cfgQ);
    end
  end

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> shReg[SH_W-1:1] == $past(shReg[SH_W-2:0]));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.parFollow && !strb.serLatch) |=> $stable(cfgQ));
  // R6
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.parFollow |=> (cfgQ.t == '0 && cfgQ.ss == '0));
  // R8
  pulse_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |-> cfgQ != $past(cfgQ));
  // R8
  no_pulse_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updatePulse |-> $stable(cfgQ));
endmodule

// File: rtl/div_cfg_port.sv
module div_cfg_port
  import div_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           serClk,
  input  logic           serData,
  input  logic           serLoad,
  input  logic           parLoad,
  input  logic [M_W-1:0] parM,
  input  logic [N_W-1:0] parN,
  output logic [M_W-1:0] outM,
  output logic [N_W-1:0] outN,
  output logic [T_W-1:0] outT,
  output logic [SS_W-1:0] outSs,
  output logic           updatePulse
);
  strb_t strb;
  cfg_t  cfgQ;

  div_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serLoad(serLoad),
    .parLoad(parLoad), .strb(strb)
  );

  div_cfg_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .serData(serData),
    .parM(parM), .parN(parN), .cfgQ(cfgQ), .updatePulse(updatePulse)
  );

  assign outM  = cfgQ.m;
  assign outN  = cfgQ.n;
  assign outT  = cfgQ.t;
  assign outSs = cfgQ.ss;
endmodule

// File: tb/div_cfg_port_tb_top.sv
`timescale 1ns/1ps
module div_cfg_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, parLoad = 1'b1;
  logic [8:0] parM = '0;
  logic [1:0] parN = '0;
  logic [8:0] outM;
  logic [1:0] outN;
  logic [2:0] outT;
  logic [3:0] outSs;
  logic       updatePulse;

  int checks = 0;
  int fails = 0;
  logic [17:0] expQ [$];
  string       tagQ [$];
  logic [17:0] modelCfg = '0;
  logic [17:0] modelSh = '0;

  always #2 clk = ~clk;

  div_cfg_port dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .parLoad(parLoad), .parM(parM), .parN(parN),
    .outM(outM), .outN(outN), .outT(outT), .outSs(outSs),
    .updatePulse(updatePulse)
  );

  function automatic logic [17:0] outWord();
    return {outSs, outT, outN, outM};
  endfunction

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectCfg(input logic [17:0] c, input string tag);
    if (c != modelCfg) begin
      expQ.push_back(c);
      tagQ.push_back(tag);
      modelCfg = c;
    end
  endtask

  task automatic checkNow(input string tag);
    checks++;
    if (outWord() !== modelCfg) begin
      fails++;
      $display("FAIL %s: outputs %h expected %h", tag, outWord(), modelCfg);
    end
  endtask

  task automatic shiftBit(input logic b);
    serData = b;
    waitNeg(4);
    serClk = 1'b1;
    modelSh = {modelSh[16:0], b};
    if (serLoad && parLoad) expectCfg(modelSh, "R3 transparent follow");
    waitNeg(4);
    serClk = 1'b0;
    waitNeg(4);
  endtask

  task automatic shiftWord(input logic [17:0] w);
    for (int i = 17; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic serPulse(input string tag);
    serLoad = 1'b1;
    if (parLoad) expectCfg(modelSh, tag);
    waitNeg(5);
    serLoad = 1'b0;
    waitNeg(6);
  endtask

  task automatic setParLoad(input logic v);
    parLoad = v;
    if (!v) expectCfg({4'b0, 3'b0, parN, parM}, "R4/R6 parallel follow");
    waitNeg(6);
  endtask

  // scoreboard monitor, R8
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && updatePulse) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R8: unexpected update, outputs %h expected %h", outWord(), modelCfg);
        end else begin
          logic [17:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (outWord() !== e) begin
            fails++;
            $display("FAIL %s: outputs %h expected %h", t, outWord(), e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [17:0] w1, w2;
    w1 = {4'b1010, 3'b101, 2'b10, 9'h1A5};
    w2 = {4'b0110, 3'b011, 2'b11, 9'h0F0};
    waitNeg(5);
    rstN = 1'b1;
    waitNeg(3);
    // R7 reset state
    checkNow("R7 reset fields");
    checks++;
    if (updatePulse !== 1'b0) begin
      fails++;
      $display("FAIL R7: pulse %b expected 0", updatePulse);
    end

    // R1: shifting without strobe leaves outputs alone
    shiftWord(w1);
    checkNow("R1 shift only, outputs held");
    // R2: strobe loads the word field by field
    serPulse("R2 serial field map");
    checkNow("R2 serial word");
    checks++;
    if (outSs !== 4'b1010 || outT !== 3'b101 || outN !== 2'b10 || outM !== 9'h1A5) begin
      fails++;
      $display("FAIL R2: fields %h %h %h %h expected a 5 2 1a5", outSs, outT, outN, outM);
    end
    // R3: hold after strobe falls
    shiftBit(1'b1); shiftBit(1'b0); shiftBit(1'b1);
    checkNow("R3 held after strobe fall");
    // R3: strobe held high while shifting (shift and latch close together)
    serLoad = 1'b1;
    expectCfg(modelSh, "R3 transparent open");
    waitNeg(6);
    shiftBit(1'b1);
    shiftBit(1'b0);
    serLoad = 1'b0;
    waitNeg(6);
    checkNow("R3 transparent result");

    // R4: pin changes ignored while control high
    parM = 9'h0C3; parN = 2'b01;
    waitNeg(8);
    checkNow("R4 pins ignored while control high");
    setParLoad(1'b0);
    checkNow("R6 quiet fields on parallel load");
    parM = 9'h111;
    expectCfg({4'b0, 3'b0, parN, parM}, "R4 parallel follow");
    waitNeg(6);
    checkNow("R4 follow");
    // R5: serial load ignored during parallel control low
    shiftWord(w2);
    serPulse("R5 ignored");
    checkNow("R5 serial strobe ignored");
    parLoad = 1'b1;
    waitNeg(6);
    parM = 9'h07E; parN = 2'b10;
    waitNeg(8);
    checkNow("R4 frozen after control rise");

    // serial after parallel, then R6 forced quiet again
    serPulse("R2 serial after parallel");
    checkNow("R2 second word");
    setParLoad(1'b0);
    checkNow("R6 test and spread cleared");
    checks++;
    if (outT !== 3'b000 || outSs !== 4'b0000) begin
      fails++;
      $display("FAIL R6: T %b SS %b expected 000 0000", outT, outSs);
    end
    parLoad = 1'b1;
    waitNeg(10);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R8: %0d updates missing expected 0", expQ.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule